// File: doc/BRIEF.md
# Reset Cause Flag Register

This block is a small status register on the processor's data bus. It remembers which kind of reset most recently hit the chip. Five sticky flags each latch one reset source: supply power-up, the external reset pin, supply brown-out, watchdog timeout and a reset requested through the JTAG test port. Reset generation logic elsewhere delivers one single-cycle pulse per source. Firmware reads the byte early after start-up to find the reset cause, then writes zeros to clear it. If firmware skips the clear, later causes accumulate, subject to the clearing rules below.

The flag storage has no reset of its own, because the reset pulses feed it as data. A flag clears in only two ways: a software write of zero to its bit, or a particular higher-ranking reset source chosen for each flag. The power-up flag is cleared by software alone. The pin, brown-out and watchdog flags are also cleared by a power-up pulse. The JTAG flag is cleared by a brown-out pulse and not by power-up. When a flag's set pulse and one of its clear conditions fall in the same cycle, the set wins.

The block has no state machine. Each flag is an independent cell whose next value is chosen in priority order: SET, then CLEAR, then HOLD. The read value follows the flag registers, so an event or write shows on the read port one clock after its edge.

Top module: `rst_cause_reg`

## Requirements
- R1: A one-cycle pulse on a source input sets its flag, visible on `rd_data` after the next rising clock edge. The bit positions are: power-up bit 0, pin bit 1, brown-out bit 2, watchdog bit 3, JTAG bit 4.
- R2: The power-up flag (bit 0) is never cleared by any source pulse. Only a write with bit 0 equal to 0 clears it.
- R3: A power-up pulse clears the pin, brown-out and watchdog flags (bits 1, 2, 3).
- R4: A brown-out pulse clears the JTAG flag (bit 4). A power-up pulse leaves the JTAG flag unchanged.
- R5: A write (`wr_en` high) clears every flag whose bit in `wr_data` is 0 and leaves every flag whose bit is 1 unchanged. With `wr_en` low, `wr_data` has no effect.
- R6: If a flag's set pulse arrives in the same cycle as one of its clear conditions (software zero or clearing source), the flag ends up set.
- R7: Bits 7 to 5 of `rd_data` always read 0, whatever is written.
- R8: A source pulse does not clear any flag except those named in R3 and R4. Without software clears, causes accumulate.
- R9: With no source pulse and no write, all flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| src_power_on | input | 1 | Power-up reset event pulse |
| src_pin | input | 1 | External pin reset event pulse |
| src_brownout | input | 1 | Brown-out reset event pulse |
| src_watchdog | input | 1 | Watchdog reset event pulse |
| src_jtag | input | 1 | JTAG-requested reset event pulse |
| wr_en | input | 1 | Write strobe from the bus |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Current register value |

## Verification
The hardest cases to reach are the same-cycle collisions, because a set and a clear of one flag must arrive on the same edge. Examples are a JTAG pulse together with a brown-out pulse, or a pin pulse together with a power-up pulse. Each collision scenario drives both inputs in one bench step so that they share an edge. Because the storage has no reset, the bench first brings every flag to a known value: a power-up pulse, then a brown-out pulse, then a write of zero. After that it checks the accumulation case, in which no clear happens between two different resets.

// File: rtl/rcause_pkg.sv
package rcause_pkg;

    localparam int unsigned FLAG_COUNT = 5;
    localparam int unsigned REG_W      = 8;

    typedef enum int unsigned {
        SRC_POWER = 0,
        SRC_PIN   = 1,
        SRC_BROWN = 2,
        SRC_WDOG  = 3,
        SRC_JTAG  = 4
    } src_idx_e;

    // Which source pulses clear a given flag (besides software).
    function automatic logic [FLAG_COUNT-1:0] hw_clear_sources(input int unsigned flag);
        logic [FLAG_COUNT-1:0] m;
        m = '0;
        unique case (flag)
            SRC_POWER: m = '0;
            SRC_PIN, SRC_BROWN, SRC_WDOG: m[SRC_POWER] = 1'b1;
            SRC_JTAG:  m[SRC_BROWN] = 1'b1;
            default:   m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rcause_sw_clear.sv
module rcause_sw_clear
    import rcause_pkg::*;
(
    input  logic                  wr_en,
    input  logic [REG_W-1:0]      wr_data,
    output logic [FLAG_COUNT-1:0] sw_clr
);
    logic unused_hi;
    assign unused_hi = ^wr_data[REG_W-1:FLAG_COUNT];

    always_comb begin
        sw_clr = '0;
        if (wr_en) begin
            sw_clr = ~wr_data[FLAG_COUNT-1:0];
        end
    end
endmodule

// File: rtl/rcause_flag_cell.sv
module rcause_flag_cell #(
    parameter int unsigned       SRC_W   = 5,
    parameter logic [SRC_W-1:0]  CLR_SRC = '0
) (
    input  logic             clk,
    input  logic             set_evt,
    input  logic [SRC_W-1:0] src_vec,
    input  logic             sw_clr,
    output logic             q
);
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SET   = 2'd1,
        ACT_CLEAR = 2'd2
    } act_e;

    act_e act;
    logic hw_clr;

    assign hw_clr = |(src_vec & CLR_SRC);

    // Priority: set beats any clear.
    always_comb begin
        if (set_evt) begin
            act = ACT_SET;
        end else if (hw_clr || sw_clr) begin
            act = ACT_CLEAR;
        end else begin
            act = ACT_HOLD;
        end
    end

    // Storage is intentionally without reset: reset pulses are data here.
    always_ff @(posedge clk) begin
        unique case (act)
            ACT_SET:   q <= 1'b1;
            ACT_CLEAR: q <= 1'b0;
            ACT_HOLD:  q <= q;
            default:   q <= q;
        endcase
    end
endmodule

// File: rtl/rcause_read_pack.sv
module rcause_read_pack
    import rcause_pkg::*;
(
    input  logic [FLAG_COUNT-1:0] flags,
    output logic [REG_W-1:0]      value
);
    localparam int unsigned PAD_W = REG_W - FLAG_COUNT;

    assign value = {{PAD_W{1'b0}}, flags};
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rcause_pkg::*;
(
    input  logic             clk,
    input  logic             src_power_on,
    input  logic             src_pin,
    input  logic             src_brownout,
    input  logic             src_watchdog,
    input  logic             src_jtag,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);
    logic [FLAG_COUNT-1:0] src_vec;
    logic [FLAG_COUNT-1:0] sw_clr;
    logic [FLAG_COUNT-1:0] flags;

    always_comb begin
        src_vec            = '0;
        src_vec[SRC_POWER] = src_power_on;
        src_vec[SRC_PIN]   = src_pin;
        src_vec[SRC_BROWN] = src_brownout;
        src_vec[SRC_WDOG]  = src_watchdog;
        src_vec[SRC_JTAG]  = src_jtag;
    end

    rcause_sw_clear u_swclr (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sw_clr  (sw_clr)
    );

    for (genvar g = 0; g < FLAG_COUNT; g++) begin : g_flag
        rcause_flag_cell #(
            .SRC_W   (FLAG_COUNT),
            .CLR_SRC (hw_clear_sources(g))
        ) u_cell (
            .clk     (clk),
            .set_evt (src_vec[g]),
            .src_vec (src_vec),
            .sw_clr  (sw_clr[g]),
            .q       (flags[g])
        );
    end

    rcause_read_pack u_pack (
        .flags (flags),
        .value (rd_data)
    );
endmodule

// File: rtl/rcause_checker.sv
module rcause_checker (
    input logic       clk,
    input logic       src_power_on,
    input logic       src_pin,
    input logic       src_brownout,
    input logic       src_watchdog,
    input logic       src_jtag,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data
);
    // Storage is undefined until the first power-up pulse.
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (src_power_on) armed <= 1'b1;
    end

    logic [4:0] srcs;
    assign srcs = {src_jtag, src_watchdog, src_brownout, src_pin, src_power_on};

    a_r1_set_on_pulse: assert property (@(posedge clk) disable iff (!armed)
        (srcs != 5'd0) |=> ((rd_data[4:0] & $past(srcs)) == $past(srcs)));

    a_r2_power_flag_sw_only: assert property (@(posedge clk) disable iff (!armed)
        $fell(rd_data[0]) |-> $past(wr_en && !wr_data[0]));

    a_r3_power_clears_pin: assert property (@(posedge clk) disable iff (!armed)
        (src_power_on && !src_pin) |=> !rd_data[1]);

    a_r3_power_clears_wdog: assert property (@(posedge clk) disable iff (!armed)
        (src_power_on && !src_watchdog) |=> !rd_data[3]);

    a_r4_brown_clears_jtag: assert property (@(posedge clk) disable iff (!armed)
        (src_brownout && !src_jtag) |=> !rd_data[4]);

    a_r6_set_beats_write: assert property (@(posedge clk) disable iff (!armed)
        (src_brownout && wr_en && !wr_data[2]) |=> rd_data[2]);

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!armed)
        rd_data[7:5] == 3'b000);

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!armed)
        (srcs == 5'd0 && !wr_en) |=> $stable(rd_data));
endmodule

bind rst_cause_reg rcause_checker u_chk (
    .clk          (clk),
    .src_power_on (src_power_on),
    .src_pin      (src_pin),
    .src_brownout (src_brownout),
    .src_watchdog (src_watchdog),
    .src_jtag     (src_jtag),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data)
);

// File: tb/rst_cause_reg_test.sv
module rst_cause_reg_test;
    logic       clk = 1'b0;
    logic       src_power_on = 1'b0;
    logic       src_pin = 1'b0;
    logic       src_brownout = 1'b0;
    logic       src_watchdog = 1'b0;
    logic       src_jtag = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Source bit order used by step(): {jtag, wdog, brown, pin, power}
    localparam logic [4:0] S_POW = 5'b00001;
    localparam logic [4:0] S_PIN = 5'b00010;
    localparam logic [4:0] S_BRN = 5'b00100;
    localparam logic [4:0] S_WDG = 5'b01000;
    localparam logic [4:0] S_JTG = 5'b10000;

    always #10 clk = ~clk;

    rst_cause_reg uut (
        .clk          (clk),
        .src_power_on (src_power_on),
        .src_pin      (src_pin),
        .src_brownout (src_brownout),
        .src_watchdog (src_watchdog),
        .src_jtag     (src_jtag),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data)
    );

    // Drive for exactly one rising edge, return at the following falling edge.
    task automatic step(input logic [4:0] src, input logic we, input logic [7:0] wd);
        @(negedge clk);
        {src_jtag, src_watchdog, src_brownout, src_pin, src_power_on} = src;
        wr_en   = we;
        wr_data = wd;
        @(negedge clk);
        {src_jtag, src_watchdog, src_brownout, src_pin, src_power_on} = 5'b0;
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic check(input logic [7:0] mask, input logic [7:0] exp, input string tag);
        checks++;
        if ((rd_data & mask) !== (exp & mask)) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h (mask %02h)", tag, rd_data, exp, mask);
        end
    endtask

    task automatic t_init;
        step(S_POW, 1'b0, 8'h00);
        check(8'hEF, 8'h01, "R1 power flag after power-up, R7 upper zero");
        step(S_BRN, 1'b0, 8'h00);
        check(8'hFF, 8'h05, "R4 brown-out clears jtag, R2 power flag kept");
        step(5'b0, 1'b1, 8'h00);
        check(8'hFF, 8'h00, "R5 write zero clears all");
    endtask

    task automatic t_accumulate;
        step(S_PIN, 1'b0, 8'h00);
        check(8'hFF, 8'h02, "R1 pin flag");
        step(S_WDG, 1'b0, 8'h00);
        check(8'hFF, 8'h0A, "R8 watchdog does not clear pin");
        step(S_JTG, 1'b0, 8'h00);
        check(8'hFF, 8'h1A, "R1 jtag flag accumulates");
        step(S_BRN, 1'b0, 8'h00);
        check(8'hFF, 8'h0E, "R4 brown-out clears jtag, R8 keeps others");
        step(S_POW, 1'b0, 8'h00);
        check(8'hFF, 8'h01, "R3 power-up clears bits 1-3");
    endtask

    task automatic t_jtag_survives_power;
        step(5'b0, 1'b1, 8'h00);
        step(S_JTG, 1'b0, 8'h00);
        check(8'hFF, 8'h10, "R1 jtag flag alone");
        step(S_POW, 1'b0, 8'h00);
        check(8'hFF, 8'h11, "R4 power-up leaves jtag");
        step(5'b0, 1'b1, 8'h10);
        check(8'hFF, 8'h10, "R5 one keeps, zero clears");
        step(5'b0, 1'b1, 8'hFF);
        check(8'hFF, 8'h10, "R5 R7 write ones no effect");
        step(5'b0, 1'b1, 8'hEF);
        check(8'hFF, 8'h00, "R5 clear jtag by write");
    endtask

    task automatic t_power_sticky;
        step(S_POW, 1'b0, 8'h00);
        step(S_PIN, 1'b0, 8'h00);
        step(S_WDG, 1'b0, 8'h00);
        step(S_BRN, 1'b0, 8'h00);
        check(8'hFF, 8'h0F, "R2 power flag survives other resets");
        step(5'b0, 1'b1, 8'hF1);
        check(8'hFF, 8'h01, "R5 partial write clear");
        step(5'b0, 1'b1, 8'hFE);
        check(8'hFF, 8'h00, "R2 power flag cleared by write zero");
    endtask

    task automatic t_collisions;
        step(S_BRN, 1'b1, 8'h00);
        check(8'hFF, 8'h04, "R6 set beats software clear");
        step(S_POW | S_PIN, 1'b0, 8'h00);
        check(8'hFF, 8'h03, "R6 pin set beats power-up clear");
        step(S_JTG | S_BRN, 1'b0, 8'h00);
        check(8'hFF, 8'h17, "R6 jtag set beats brown-out clear");
    endtask

    task automatic t_hold;
        repeat (5) @(negedge clk);
        check(8'hFF, 8'h17, "R9 hold when idle");
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
        @(negedge clk);
        check(8'hFF, 8'h17, "R5 data ignored without strobe");
        check(8'hE0, 8'h00, "R7 upper bits zero");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_init();
        t_accumulate();
        t_jtag_survives_power();
        t_power_sticky();
        t_collisions();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule